// File: doc/BRIEF.md
# Load/Store Ordering Queue with Store-to-Load Forwarding

This block keeps in-flight memory operations in program order in a small ring of slots, twelve by default. The front end allocates a slot for each load or store, and later writes back its address and, for a store, its data. Each cycle the block offers the oldest load that can complete. It decides by comparing the load's page-offset bits against every older store still held in the ring.

When no older store shares those bits, the load goes ahead of the stores and is marked for the cache. When one or more match, the youngest of them supplies the load value directly. A store never reaches memory before it retires. Retired stores leave through a drain port, oldest first, one per cycle. A flush discards speculative entries younger than a chosen slot, or all entries that have not retired.

The load result port and the store drain port are valid/ready streams. A drain offer, once raised, holds its address and data until `st_ready` takes it. The load offer always presents the oldest eligible load, so it may change before it is accepted. An acceptance applies to the slot shown in that cycle. Allocation is valid/ready. Retire and flush are plain control pins.

Top module: `lsq_top`

## Requirements
- R1: `alloc_ready` is high exactly when fewer than DEPTH slots are occupied and `flush_valid` is low. `alloc_idx` names the slot the next allocation takes. Slots are handed out in ring order 0,1,…,DEPTH-1,0,… starting at 0 after reset. An allocation request while `alloc_ready` is low is ignored.
- R2: A load is compared, on address bits [OFS_W-1:0] (OFS_W=12), against every occupied older store, including retired stores not yet drained. With no match it is offered with `ld_fwd`=0 and `ld_data`=0.
- R3: With one or more matching older stores, the load is offered with `ld_fwd`=1 and `ld_data` equal to the data of the youngest matching older store.
- R4: A load is not offered while any older store lacks its address, or while the youngest matching older store lacks its data. It is offered once the missing value is written.
- R5: `ld_valid` presents the oldest offerable load (address known, not yet accepted), and `ld_idx` is its slot. A load accepted with `ld_ready` is never offered again.
- R6: `retire_ok` is high when the oldest non-retired entry is complete: a store with address and data, or a load already accepted. A `retire` pulse then retires that entry. A `retire` pulse while `retire_ok` is low is ignored.
- R7: Stores leave only through the drain port and only after retiring, oldest first, one per cycle. `st_valid` with `st_addr`/`st_data` holds until `st_ready`. Retired loads free their slot without using the port.
- R8: Address or data writebacks to an unoccupied slot or to a retired entry are ignored. Data writebacks to loads are ignored.
- R9: With `flush_valid` high and `flush_all`=0, the entries up to and including slot `flush_idx` are kept and every younger entry is removed. With `flush_all`=1, every non-retired entry is removed. Retired entries are never removed. A `flush_idx` that is not occupied is ignored. In the flush cycle, allocate, retire and the load offer are blocked.
- R10: After reset the queue is empty: `alloc_ready`=1, `alloc_idx`=0, `ld_valid`=0, `st_valid`=0, `retire_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | Slot available |
| alloc_idx | output | IDX_W | Slot given to the allocation |
| addr_valid | input | 1 | Address writeback strobe |
| addr_idx | input | IDX_W | Slot for the address |
| addr_val | input | ADDR_W | Address value |
| data_valid | input | 1 | Store data writeback strobe |
| data_idx | input | IDX_W | Slot for the data |
| data_val | input | DATA_W | Store data value |
| ld_valid | output | 1 | Load result offered |
| ld_ready | input | 1 | Load result accepted |
| ld_idx | output | IDX_W | Slot of offered load |
| ld_addr | output | ADDR_W | Address of offered load |
| ld_fwd | output | 1 | 1 = data forwarded, 0 = go to cache |
| ld_data | output | DATA_W | Forwarded data, 0 when not forwarded |
| retire | input | 1 | Retire the oldest non-retired entry |
| retire_ok | output | 1 | Oldest non-retired entry is complete |
| st_valid | output | 1 | Retired store offered to memory |
| st_ready | input | 1 | Memory accepts the store |
| st_addr | output | ADDR_W | Drained store address |
| st_data | output | DATA_W | Drained store data |
| flush_valid | input | 1 | Flush request |
| flush_all | input | 1 | Remove all non-retired entries |
| flush_idx | input | IDX_W | Youngest slot kept on a partial flush |

## Verification
Forwarding is driven by a table of store-store-load triples. The triples cover no match, a match on the older store only, a match on both stores, and a match on the younger store only. They also include matches where the upper address bits differ and near misses one offset apart. Together they separate full-address compares from page-offset compares, and youngest from oldest selection. Directed sequences cover:
- a stall on missing store data or an unknown store address;
- forwarding from a retired but undrained store;
- a late data write to that retired store;
- drain back-pressure;
- a full ring, a partial flush and a full flush.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef struct packed {
    logic is_st;   // entry is a store
    logic a_ok;    // address written
    logic d_ok;    // store data written
    logic done;    // load result accepted
  } lsq_flags_t;

  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  function automatic int unsigned ring_age(input int unsigned idx,
                                           input int unsigned head,
                                           input int unsigned depth);
    return (idx >= head) ? (idx - head) : (idx + depth - head);
  endfunction

endpackage

// File: rtl/lsq_ring_ctrl.sv
module lsq_ring_ctrl #(
  parameter int DEPTH = 12,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             drain_fire,
  input  logic             flush_fire,
  input  logic [CNT_W-1:0] flush_keep,
  output logic [IDX_W-1:0] head,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rcnt,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] rptr
);
  import lsq_pkg::*;

  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    if (flush_fire) cnt_nx = flush_keep - CNT_W'(drain_fire);
    else            cnt_nx = cnt + CNT_W'(alloc_fire) - CNT_W'(drain_fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
      rcnt <= '0;
    end else begin
      if (drain_fire) head <= IDX_W'(ring_add(32'(head), 1, DEPTH));
      cnt  <= cnt_nx;
      rcnt <= rcnt + CNT_W'(retire_fire) - CNT_W'(drain_fire);
    end
  end

  assign tail = IDX_W'(ring_add(32'(head), 32'(cnt), DEPTH));
  assign rptr = IDX_W'(ring_add(32'(head), 32'(rcnt), DEPTH));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R1
  AST_RET_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= cnt); // R6

endmodule

// File: rtl/lsq_fwd_pick.sv
module lsq_fwd_pick #(
  parameter int DEPTH  = 12,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 12,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic [IDX_W-1:0]          head,
  input  logic [CNT_W-1:0]          cnt,
  input  lsq_pkg::lsq_flags_t       flags [DEPTH],
  input  logic [ADDR_W-1:0]         addrs [DEPTH],
  input  logic [DATA_W-1:0]         datas [DEPTH],
  output logic                      pick_valid,
  output logic [IDX_W-1:0]          pick_idx,
  output logic                      pick_fwd,
  output logic [DATA_W-1:0]         pick_data
);
  import lsq_pkg::*;

  // Scan loads oldest first; for each, walk its older stores oldest to
  // youngest so the last match seen is the youngest one.
  always_comb begin
    int unsigned pl;
    int unsigned pb;
    logic blk;
    logic hit;
    logic hd;
    logic [DATA_W-1:0] hdat;
    pick_valid = 1'b0;
    pick_idx   = '0;
    pick_fwd   = 1'b0;
    pick_data  = '0;
    for (int la = 0; la < DEPTH; la++) begin
      pl   = ring_add(32'(head), 32'(la), DEPTH);
      blk  = 1'b0;
      hit  = 1'b0;
      hd   = 1'b0;
      hdat = '0;
      for (int lb = 0; lb < DEPTH; lb++) begin
        pb = ring_add(32'(head), 32'(lb), DEPTH);
        if (lb < la && flags[pb].is_st) begin
          if (!flags[pb].a_ok) begin
            blk = 1'b1;
          end else if (addrs[pb][OFS_W-1:0] == addrs[pl][OFS_W-1:0]) begin
            hit  = 1'b1;
            hd   = flags[pb].d_ok;
            hdat = datas[pb];
          end
        end
      end
      if (!pick_valid && 32'(la) < 32'(cnt) && !flags[pl].is_st &&
          flags[pl].a_ok && !flags[pl].done && !blk && (!hit || hd)) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(pl);
        pick_fwd   = hit;
        pick_data  = hit ? hdat : '0;
      end
    end
  end

endmodule

// File: rtl/lsq_top.sv
module lsq_top #(
  parameter int DEPTH  = 12,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              addr_valid,
  input  logic [IDX_W-1:0]  addr_idx,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              data_valid,
  input  logic [IDX_W-1:0]  data_idx,
  input  logic [DATA_W-1:0] data_val,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [IDX_W-1:0]  ld_idx,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              ld_fwd,
  output logic [DATA_W-1:0] ld_data,
  input  logic              retire,
  output logic              retire_ok,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  input  logic              flush_valid,
  input  logic              flush_all,
  input  logic [IDX_W-1:0]  flush_idx
);
  import lsq_pkg::*;

  lsq_flags_t        flags [DEPTH];
  logic [ADDR_W-1:0] addrs [DEPTH];
  logic [DATA_W-1:0] datas [DEPTH];

  logic [IDX_W-1:0] head, tail, rptr;
  logic [CNT_W-1:0] cnt, rcnt, flush_keep;
  logic [DEPTH-1:0] occ, ret;
  logic alloc_fire, retire_fire, drain_fire, flush_fire, ld_fire;
  logic pick_valid, pick_fwd;
  logic [IDX_W-1:0] pick_idx;
  logic [DATA_W-1:0] pick_data;
  int unsigned fage;

  lsq_ring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .retire_fire(retire_fire),
    .drain_fire(drain_fire), .flush_fire(flush_fire),
    .flush_keep(flush_keep),
    .head(head), .cnt(cnt), .rcnt(rcnt), .tail(tail), .rptr(rptr)
  );

  lsq_fwd_pick #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .OFS_W(OFS_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
    .head(head), .cnt(cnt), .flags(flags), .addrs(addrs), .datas(datas),
    .pick_valid(pick_valid), .pick_idx(pick_idx),
    .pick_fwd(pick_fwd), .pick_data(pick_data)
  );

  // Allocation
  assign alloc_ready = (cnt < CNT_W'(DEPTH)) && !flush_valid;
  assign alloc_idx   = tail;
  assign alloc_fire  = alloc_valid && alloc_ready;

  // Flush: keep up to flush_idx, never below the retired count
  always_comb begin
    fage       = ring_age(32'(flush_idx), 32'(head), DEPTH);
    flush_fire = flush_valid &&
                 (flush_all || (32'(flush_idx) < DEPTH && fage < 32'(cnt)));
    if (flush_all || (fage + 1 < 32'(rcnt))) flush_keep = rcnt;
    else                                     flush_keep = CNT_W'(fage + 1);
  end

  // Retire the oldest non-retired entry once complete
  always_comb begin
    retire_ok = 1'b0;
    if (!flush_valid && cnt > rcnt) begin
      if (flags[rptr].is_st) retire_ok = flags[rptr].a_ok && flags[rptr].d_ok;
      else                   retire_ok = flags[rptr].done;
    end
  end
  assign retire_fire = retire && retire_ok;

  // Drain: retired head leaves; stores via the port, loads silently
  assign st_valid   = (rcnt != '0) && flags[head].is_st;
  assign st_addr    = addrs[head];
  assign st_data    = datas[head];
  assign drain_fire = (rcnt != '0) && (!flags[head].is_st || st_ready);

  // Load result port
  assign ld_valid = pick_valid && !flush_valid;
  assign ld_idx   = pick_idx;
  assign ld_addr  = addrs[pick_idx];
  assign ld_fwd   = pick_fwd;
  assign ld_data  = pick_data;
  assign ld_fire  = ld_valid && ld_ready;

  // Per-slot storage
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign occ[i] = ring_age(i, 32'(head), DEPTH) < 32'(cnt);
    assign ret[i] = ring_age(i, 32'(head), DEPTH) < 32'(rcnt);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= '0;
        addrs[i] <= '0;
        datas[i] <= '0;
      end else if (alloc_fire && tail == IDX_W'(i)) begin
        flags[i]       <= '0;
        flags[i].is_st <= alloc_is_store;
      end else if (occ[i] && !ret[i]) begin
        if (addr_valid && addr_idx == IDX_W'(i)) begin
          addrs[i]      <= addr_val;
          flags[i].a_ok <= 1'b1;
        end
        if (data_valid && data_idx == IDX_W'(i) && flags[i].is_st) begin
          datas[i]      <= data_val;
          flags[i].d_ok <= 1'b1;
        end
        if (ld_fire && pick_idx == IDX_W'(i)) flags[i].done <= 1'b1;
      end
    end
  end

  AST_LD_IS_PENDING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (occ[ld_idx] && !flags[ld_idx].is_st &&
                  flags[ld_idx].a_ok && !flags[ld_idx].done)); // R5
  AST_NO_REOFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !(ld_valid && ld_idx == $past(ld_idx))); // R5
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=>
      (st_valid && $stable(st_addr) && $stable(st_data))); // R7
  AST_DRAIN_RETIRED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> ret[head]); // R7

endmodule

// File: tb/sim_lsq_top.sv
module sim_lsq_top;
  localparam int DEPTH = 12;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_is_store = 0, alloc_ready;
  logic [IDX_W-1:0] alloc_idx;
  logic addr_valid = 0; logic [IDX_W-1:0] addr_idx = '0; logic [31:0] addr_val = '0;
  logic data_valid = 0; logic [IDX_W-1:0] data_idx = '0; logic [31:0] data_val = '0;
  logic ld_valid, ld_ready = 0, ld_fwd;
  logic [IDX_W-1:0] ld_idx;
  logic [31:0] ld_addr, ld_data;
  logic retire = 0, retire_ok;
  logic st_valid, st_ready = 0;
  logic [31:0] st_addr, st_data;
  logic flush_valid = 0, flush_all = 0;
  logic [IDX_W-1:0] flush_idx = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done_run = 0;

  always #5 clk = ~clk;

  lsq_top u0 (.*);

  typedef struct packed {
    logic [31:0] a0;
    logic [31:0] a1;
    logic [31:0] al;
    logic [1:0]  src;   // 0 none, 1 older store, 2 younger store
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_1000, 32'h0000_2004, 32'h0000_3008, 2'd0},
    '{32'h0000_1010, 32'h0000_2020, 32'h0000_5010, 2'd1},
    '{32'h0000_1010, 32'h0000_2010, 32'h0000_9010, 2'd2},
    '{32'h0000_1ABC, 32'h0000_2FFF, 32'h0000_7FFF, 2'd2},
    '{32'h0000_1234, 32'h0000_5678, 32'h1234_5234, 2'd1},
    '{32'h0000_0FFF, 32'h0000_1000, 32'h0000_2000, 2'd2},
    '{32'h0000_4444, 32'h0000_4444, 32'h0000_4444, 2'd2},
    '{32'h0000_0800, 32'h0000_0801, 32'h0000_0802, 2'd0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input int i, input int k);
    return (i + k) % DEPTH;
  endfunction

  // All tasks start and end at a falling edge
  task automatic do_alloc(input bit st, output int idx);
    alloc_valid = 1; alloc_is_store = st; #1;
    idx = int'(alloc_idx);
    @(negedge clk); alloc_valid = 0; alloc_is_store = 0;
  endtask

  task automatic wr_addr(input int idx, input logic [31:0] a);
    addr_valid = 1; addr_idx = IDX_W'(idx); addr_val = a;
    @(negedge clk); addr_valid = 0;
  endtask

  task automatic wr_data(input int idx, input logic [31:0] d);
    data_valid = 1; data_idx = IDX_W'(idx); data_val = d;
    @(negedge clk); data_valid = 0;
  endtask

  task automatic take_load(input string req, input int idx,
                           input bit fwd, input logic [31:0] d);
    ld_ready = 1; #1;
    chk(req, "ld_valid", 32'(ld_valid), 1);
    chk(req, "ld_idx", 32'(ld_idx), 32'(idx));
    chk(req, "ld_fwd", 32'(ld_fwd), 32'(fwd));
    chk(req, "ld_data", ld_data, d);
    @(negedge clk); ld_ready = 0;
  endtask

  task automatic do_retire(input string req, input bit exp_ok);
    retire = 1; #1;
    chk(req, "retire_ok", 32'(retire_ok), 32'(exp_ok));
    @(negedge clk); retire = 0;
  endtask

  task automatic drain(input string req, input logic [31:0] a, input logic [31:0] d);
    st_ready = 1; #1;
    chk(req, "st_valid", 32'(st_valid), 1);
    chk(req, "st_addr", st_addr, a);
    chk(req, "st_data", st_data, d);
    @(negedge clk); st_ready = 0;
  endtask

  task automatic summary;
    if (!done_run) begin
      done_run = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int i0, i1, i2;
    int ids [DEPTH];
    int f;
    logic [31:0] d0, d1, expd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk("R10", "alloc_ready", 32'(alloc_ready), 1);
    chk("R10", "alloc_idx", 32'(alloc_idx), 0);
    chk("R10", "ld_valid", 32'(ld_valid), 0);
    chk("R10", "st_valid", 32'(st_valid), 0);
    chk("R10", "retire_ok", 32'(retire_ok), 0);
    @(negedge clk);

    // Table-driven forwarding (R1 R2 R3 R6 R7)
    for (int k = 0; k < 8; k++) begin
      d0 = 32'hA000_0000 + 32'(k);
      d1 = 32'hB000_0000 + 32'(k);
      do_alloc(1, i0);
      do_alloc(1, i1);
      do_alloc(0, i2);
      if (k == 0) chk("R1", "first slot", 32'(i0), 0);
      chk("R1", "ring order", 32'(i1), 32'(nxt(i0, 1)));
      chk("R1", "ring order", 32'(i2), 32'(nxt(i0, 2)));
      wr_addr(i0, VECS[k].a0);
      wr_addr(i1, VECS[k].a1);
      wr_addr(i2, VECS[k].al);
      wr_data(i0, d0);
      wr_data(i1, d1);
      expd = (VECS[k].src == 2) ? d1 : (VECS[k].src == 1) ? d0 : 32'h0;
      take_load((VECS[k].src == 0) ? "R2" : "R3", i2, VECS[k].src != 0, expd);
      do_retire("R6", 1);
      do_retire("R6", 1);
      do_retire("R6", 1);
      drain("R7", VECS[k].a0, d0);
      drain("R7", VECS[k].a1, d1);
      @(negedge clk);
    end

    // R4: stall on missing store data
    do_alloc(1, i0);
    do_alloc(0, i1);
    wr_addr(i0, 32'h0000_0040);
    wr_addr(i1, 32'h0000_1040);
    #1 chk("R4", "ld_valid no data", 32'(ld_valid), 0);
    wr_data(i0, 32'h55);
    take_load("R4", i1, 1, 32'h55);
    do_retire("R6", 1);
    do_retire("R6", 1);
    drain("R7", 32'h0000_0040, 32'h55);
    @(negedge clk);

    // R4: unknown older store address blocks; then bypass (R2); R6 incomplete
    do_alloc(1, i0);
    do_alloc(0, i1);
    wr_addr(i1, 32'h0000_2300);
    #1 chk("R4", "ld_valid unknown addr", 32'(ld_valid), 0);
    wr_addr(i0, 32'h0000_2301);
    take_load("R2", i1, 0, 32'h0);
    do_retire("R6", 0);
    wr_data(i0, 32'h77);
    do_retire("R6", 1);
    do_retire("R6", 1);
    drain("R7", 32'h0000_2301, 32'h77);
    @(negedge clk);

    // R8 R7 R3: retired store forwards, ignores late data, holds under back-pressure
    do_alloc(1, i0);
    wr_addr(i0, 32'h0000_03A0);
    wr_data(i0, 32'h1111);
    do_retire("R6", 1);
    #1 chk("R7", "st_valid after retire", 32'(st_valid), 1);
    wr_data(i0, 32'h2222);
    do_alloc(0, i1);
    wr_addr(i1, 32'h0000_53A0);
    take_load("R8", i1, 1, 32'h1111);
    #1 chk("R7", "st_data held", st_data, 32'h1111);
    do_retire("R6", 1);
    drain("R8", 32'h0000_03A0, 32'h1111);
    @(negedge clk);

    // R1 R9: full ring, partial flush, full flush
    for (int k = 0; k < DEPTH; k++) begin
      int t;
      do_alloc(0, t);
      ids[k] = t;
    end
    f = ids[0];
    #1 chk("R1", "alloc_ready full", 32'(alloc_ready), 0);
    alloc_valid = 1; @(negedge clk); alloc_valid = 0;
    flush_valid = 1; flush_all = 0; flush_idx = IDX_W'(ids[2]); #1;
    chk("R9", "alloc_ready in flush", 32'(alloc_ready), 0);
    @(negedge clk); flush_valid = 0; #1;
    chk("R9", "alloc_ready after flush", 32'(alloc_ready), 1);
    chk("R9", "alloc_idx after flush", 32'(alloc_idx), 32'(nxt(f, 3)));
    wr_addr(ids[5], 32'h0000_0100);
    #1 chk("R8", "write to removed slot", 32'(ld_valid), 0);
    wr_addr(ids[1], 32'h0000_0200);
    #1 chk("R9", "kept load offered", 32'(ld_valid), 1);
    chk("R9", "kept load idx", 32'(ld_idx), 32'(ids[1]));
    flush_valid = 1; flush_all = 1; #1;
    chk("R9", "ld_valid blocked in flush", 32'(ld_valid), 0);
    @(negedge clk); flush_valid = 0; flush_all = 0; #1;
    chk("R9", "alloc_idx after full flush", 32'(alloc_idx), 32'(f));
    chk("R9", "ld_valid after full flush", 32'(ld_valid), 0);
    @(negedge clk);

    summary();
  end

endmodule